// File: doc/BRIEF.md
# Synthesizer Programming Word Decoder

This block turns a stream of 16-bit programming words into the register contents that a numerically controlled oscillator core needs. Each word arrives on a valid/ready input. Its two top bits choose where it goes: a small control register, one of two 28-bit frequency words, or one of two 12-bit phase offsets. All register contents are presented continuously on output ports for the oscillator core.

Frequency words are 28 bits wide but are written 14 bits at a time. The two control bits decide how each 14-bit payload is placed. In paired mode, successive writes to the same frequency word fill the low half and then the high half. Each frequency word has its own pairing state, and a control write resets that state. In split mode, every write goes to one fixed half, picked by the half-select control bit, and the other half is left alone.

Each half write takes effect as soon as it is accepted. A full reload in paired mode therefore passes through a mixed value for one write. The input never applies back-pressure: `in_ready` stays high, and a word is taken on every clock edge where `in_valid` is high. No word is buffered or dropped.

Top module: `dds_word_decoder`

## Requirements
- R1: After reset, both frequency words, both phase offsets and both control bits are zero, and `in_ready` is high.
- R2: An accepted word with bits [15:14]=00 loads `full_mode_o` from bit 13 and `half_sel_o` from bit 12. It changes no frequency or phase output.
- R3: With `full_mode_o`=1, the first write to a frequency word after a control write (or after reset) replaces bits [13:0] with the payload (word bits [13:0]). Bits [27:14] are unchanged, and the new value is visible one cycle after acceptance.
- R4: With `full_mode_o`=1, the next write to the same frequency word replaces bits [27:14]. The words 0x2000, 0x4000, 0x7FFF leave frequency word 0 at 0xFFFC000.
- R5: Frequency word 0 (route 01) and frequency word 1 (route 10) keep separate low/high pairing state, so interleaved paired writes to both load each correctly.
- R6: A control write makes the next paired write to either frequency word go to the low half again.
- R7: With `full_mode_o`=0 and `half_sel_o`=0, a frequency write replaces bits [13:0] only.
- R8: With `full_mode_o`=0 and `half_sel_o`=1, a frequency write replaces bits [27:14] only.
- R9: A word with bits [15:14]=11 loads bits [11:0] into phase offset 0 when bit 13 is 0, or into phase offset 1 when bit 13 is 1. Bit 12 has no effect, and the other phase offset and both frequency words stay unchanged.
- R10: When `in_valid` is low, no output changes, whatever `in_word` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Programming word present |
| in_ready | output | 1 | Always high; the word is taken when valid |
| in_word | input | 16 | Programming word |
| freq0_o | output | 28 | Frequency word 0 |
| freq1_o | output | 28 | Frequency word 1 |
| phase0_o | output | 12 | Phase offset 0 |
| phase1_o | output | 12 | Phase offset 1 |
| full_mode_o | output | 1 | Paired 28-bit write mode |
| half_sel_o | output | 1 | Half selected in split mode (1 = high) |

## Verification
Paired writes are tried in three ways: one word alone, the two words interleaved, and a control write in the middle of a pair. These show whether pairing state is kept per word and whether a control write resets it. Split writes sweep many payloads into each half of each word, with different values already in the other half, so a write landing in the wrong half shows up. Phase writes sweep the 12-bit range with both sub-address values and both settings of the ignored bit. Idle cycles with changing word content check that unaccepted input leaves all outputs as they were.

// File: rtl/dds_dec_pkg.sv
package dds_dec_pkg;
  typedef enum logic [1:0] {
    RT_CTRL  = 2'b00,
    RT_FREQ0 = 2'b01,
    RT_FREQ1 = 2'b10,
    RT_PHASE = 2'b11
  } route_e;
endpackage

// File: rtl/dds_word_route.sv
module dds_word_route
  import dds_dec_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int HALF_W = 14,
  parameter int PH_W   = 12,
  parameter int NUM_PH = 2
) (
  input  logic              take,
  input  logic [WORD_W-1:0] word,
  output logic              ctrl_we,
  output logic              ctrl_full,
  output logic              ctrl_half,
  output logic [1:0]        freq_we,
  output logic [HALF_W-1:0] freq_data,
  output logic [NUM_PH-1:0] phase_we,
  output logic [PH_W-1:0]   phase_data
);
  localparam int SEL_BIT = WORD_W - 3;

  route_e route;

  always_comb begin
    route      = route_e'(word[WORD_W-1 -: 2]);
    ctrl_we    = take && (route == RT_CTRL);
    ctrl_full  = word[WORD_W-3];
    ctrl_half  = word[WORD_W-4];
    freq_we[0] = take && (route == RT_FREQ0);
    freq_we[1] = take && (route == RT_FREQ1);
    freq_data  = word[HALF_W-1:0];
    phase_data = word[PH_W-1:0];
    phase_we   = '0;
    if (take && (route == RT_PHASE))
      phase_we[word[SEL_BIT]] = 1'b1;
  end
endmodule

// File: rtl/dds_freq_slot.sv
module dds_freq_slot #(
  parameter int HALF_W = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic                rearm,
  input  logic                full_mode,
  input  logic                half_sel,
  input  logic [HALF_W-1:0]   data,
  output logic [2*HALF_W-1:0] value
);
  logic [HALF_W-1:0] lo_q, hi_q;
  logic              expect_hi_q;
  logic              put_hi;

  always_comb begin
    put_hi = full_mode ? expect_hi_q : half_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q        <= '0;
      hi_q        <= '0;
      expect_hi_q <= 1'b0;
    end else begin
      if (rearm) begin
        expect_hi_q <= 1'b0;
      end else if (we) begin
        if (put_hi) hi_q <= data;
        else        lo_q <= data;
        if (full_mode) expect_hi_q <= ~expect_hi_q;
      end
    end
  end

  assign value = {hi_q, lo_q};
endmodule

// File: rtl/dds_phase_bank.sv
module dds_phase_bank #(
  parameter int PH_W   = 12,
  parameter int NUM_PH = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PH-1:0]           we,
  input  logic [PH_W-1:0]             data,
  output logic [NUM_PH-1:0][PH_W-1:0] value
);
  for (genvar g = 0; g < NUM_PH; g++) begin : g_ph
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     value[g] <= '0;
      else if (we[g]) value[g] <= data;
    end
  end
endmodule

// File: rtl/dds_word_decoder.sv
module dds_word_decoder #(
  parameter int WORD_W = 16,
  parameter int HALF_W = 14,
  parameter int PH_W   = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [WORD_W-1:0]   in_word,
  output logic [2*HALF_W-1:0] freq0_o,
  output logic [2*HALF_W-1:0] freq1_o,
  output logic [PH_W-1:0]     phase0_o,
  output logic [PH_W-1:0]     phase1_o,
  output logic                full_mode_o,
  output logic                half_sel_o
);
  localparam int NUM_F  = 2;
  localparam int NUM_PH = 2;
  localparam int FW     = 2 * HALF_W;

  logic                        take;
  logic                        ctrl_we, ctrl_full, ctrl_half;
  logic [NUM_F-1:0]            freq_we;
  logic [HALF_W-1:0]           freq_data;
  logic [NUM_PH-1:0]           phase_we;
  logic [PH_W-1:0]             phase_data;
  logic [NUM_F-1:0][FW-1:0]    freq_val;
  logic [NUM_PH-1:0][PH_W-1:0] phase_val;
  logic                        full_q, half_q;

  assign in_ready = 1'b1;
  assign take     = in_valid && in_ready;

  dds_word_route #(
    .WORD_W(WORD_W), .HALF_W(HALF_W), .PH_W(PH_W), .NUM_PH(NUM_PH)
  ) route_i (
    .take      (take),
    .word      (in_word),
    .ctrl_we   (ctrl_we),
    .ctrl_full (ctrl_full),
    .ctrl_half (ctrl_half),
    .freq_we   (freq_we),
    .freq_data (freq_data),
    .phase_we  (phase_we),
    .phase_data(phase_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      half_q <= 1'b0;
    end else if (ctrl_we) begin
      full_q <= ctrl_full;
      half_q <= ctrl_half;
    end
  end

  for (genvar g = 0; g < NUM_F; g++) begin : g_freq
    dds_freq_slot #(.HALF_W(HALF_W)) slot_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (freq_we[g]),
      .rearm    (ctrl_we),
      .full_mode(full_q),
      .half_sel (half_q),
      .data     (freq_data),
      .value    (freq_val[g])
    );
  end

  dds_phase_bank #(.PH_W(PH_W), .NUM_PH(NUM_PH)) phase_i (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (phase_we),
    .data (phase_data),
    .value(phase_val)
  );

  assign freq0_o     = freq_val[0];
  assign freq1_o     = freq_val[1];
  assign phase0_o    = phase_val[0];
  assign phase1_o    = phase_val[1];
  assign full_mode_o = full_q;
  assign half_sel_o  = half_q;
endmodule

// File: rtl/dds_word_decoder_chk.sv
module dds_word_decoder_chk #(
  parameter int WORD_W = 16,
  parameter int HALF_W = 14,
  parameter int PH_W   = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic [WORD_W-1:0]   in_word,
  input logic [2*HALF_W-1:0] freq0_o,
  input logic [2*HALF_W-1:0] freq1_o,
  input logic [PH_W-1:0]     phase0_o,
  input logic [PH_W-1:0]     phase1_o,
  input logic                full_mode_o,
  input logic                half_sel_o
);
  localparam int FW = 2 * HALF_W;
  logic [1:0] rt;
  assign rt = in_word[WORD_W-1 -: 2];

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(freq0_o) && $stable(freq1_o) && $stable(phase0_o)
                   && $stable(phase1_o) && $stable(full_mode_o) && $stable(half_sel_o)));

  // R2
  ctrl_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && rt == 2'b00) |=>
      ($stable(freq0_o) && $stable(freq1_o) && $stable(phase0_o) && $stable(phase1_o)
       && full_mode_o == $past(in_word[WORD_W-3]) && half_sel_o == $past(in_word[WORD_W-4])));

  // R9
  phase_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && rt == 2'b11 && !in_word[WORD_W-3]) |=>
      (phase0_o == $past(in_word[PH_W-1:0]) && $stable(phase1_o)
       && $stable(freq0_o) && $stable(freq1_o)));

  // R7
  fine_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && rt == 2'b01 && !full_mode_o && !half_sel_o) |=>
      (freq0_o[HALF_W-1:0] == $past(in_word[HALF_W-1:0])
       && freq0_o[FW-1:HALF_W] == $past(freq0_o[FW-1:HALF_W])));

  // R8
  coarse_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && rt == 2'b10 && !full_mode_o && half_sel_o) |=>
      (freq1_o[FW-1:HALF_W] == $past(in_word[HALF_W-1:0])
       && freq1_o[HALF_W-1:0] == $past(freq1_o[HALF_W-1:0])
       && $stable(freq0_o)));
endmodule

bind dds_word_decoder dds_word_decoder_chk #(
  .WORD_W(WORD_W), .HALF_W(HALF_W), .PH_W(PH_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_word(in_word), .freq0_o(freq0_o), .freq1_o(freq1_o),
  .phase0_o(phase0_o), .phase1_o(phase1_o),
  .full_mode_o(full_mode_o), .half_sel_o(half_sel_o)
);

// File: tb/dds_word_decoder_tb.sv
module dds_word_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_word = '0;
  logic [27:0] freq0_o, freq1_o;
  logic [11:0] phase0_o, phase1_o;
  logic        full_mode_o, half_sel_o;

  int checks = 0;
  int failures = 0;
  logic [27:0] e_f0 = '0, e_f1 = '0;
  logic [11:0] e_p0 = '0, e_p1 = '0;
  logic        e_full = 1'b0, e_half = 1'b0;

  always #2.5 clk = ~clk;

  dds_word_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .freq0_o(freq0_o), .freq1_o(freq1_o),
    .phase0_o(phase0_o), .phase1_o(phase1_o),
    .full_mode_o(full_mode_o), .half_sel_o(half_sel_o)
  );

  task automatic chk(input string req, input logic [27:0] act, input logic [27:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk({req, " freq0"}, freq0_o, e_f0);
    chk({req, " freq1"}, freq1_o, e_f1);
    chk({req, " phase0"}, {16'd0, phase0_o}, {16'd0, e_p0});
    chk({req, " phase1"}, {16'd0, phase1_o}, {16'd0, e_p1});
    chk({req, " full"}, {27'd0, full_mode_o}, {27'd0, e_full});
    chk({req, " half"}, {27'd0, half_sel_o}, {27'd0, e_half});
  endtask

  task automatic send(input logic [15:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic set_ctrl(input logic full, input logic half);
    send({2'b00, full, half, 12'h5A5});
    e_full = full;
    e_half = half;
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk_all("R1");
    chk("R1 ready", {27'd0, in_ready}, 28'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1");

    // R2 control writes in all four combinations
    for (int c = 0; c < 4; c++) begin
      set_ctrl(c[1], c[0]);
      chk_all("R2");
    end

    // R3 R4 paired load with visible intermediate
    set_ctrl(1'b1, 1'b0);
    send(16'h4000 | 16'h1234);
    e_f0 = {14'd0, 14'h1234};
    chk_all("R3");
    send(16'h4000 | 16'h2AAA);
    e_f0 = {14'h2AAA, 14'h1234};
    chk_all("R4");
    send(16'h2000); e_full = 1'b1; e_half = 1'b0;
    send(16'h4000);
    e_f0 = {14'h2AAA, 14'h0000};
    chk_all("R3 intermediate");
    send(16'h7FFF);
    e_f0 = 28'hFFFC000;
    chk_all("R4 example");

    // R5 interleaved paired writes
    for (int i = 0; i < 40; i++) begin
      logic [13:0] a_lo, a_hi, b_lo, b_hi;
      a_lo = 14'(i * 397 + 5);
      a_hi = 14'(i * 1021 + 77);
      b_lo = 14'(16383 - i * 211);
      b_hi = 14'(i * 4093);
      send({2'b01, a_lo}); e_f0[13:0] = a_lo;
      send({2'b10, b_lo}); e_f1[13:0] = b_lo;
      chk_all("R5 lo");
      send({2'b01, a_hi}); e_f0[27:14] = a_hi;
      send({2'b10, b_hi}); e_f1[27:14] = b_hi;
      chk_all("R5 hi");
    end

    // R6 control write re-arms low half
    send({2'b10, 14'h0111}); e_f1[13:0] = 14'h0111;
    set_ctrl(1'b1, 1'b1);
    send({2'b10, 14'h0222}); e_f1[13:0] = 14'h0222;
    chk_all("R6");
    send({2'b10, 14'h0333}); e_f1[27:14] = 14'h0333;
    chk_all("R6 follow");

    // R7 fine writes, low half only
    set_ctrl(1'b0, 1'b0);
    send(16'hBFFF); e_f1[13:0] = 14'h3FFF;
    chk_all("R7 example");
    for (int i = 0; i < 64; i++) begin
      logic [13:0] v;
      v = 14'(i * 257 + 3);
      send({(i % 2 == 0) ? 2'b01 : 2'b10, v});
      if (i % 2 == 0) e_f0[13:0] = v; else e_f1[13:0] = v;
      chk_all("R7");
    end

    // R8 coarse writes, high half only
    set_ctrl(1'b0, 1'b1);
    send(16'h40FF); e_f0[27:14] = 14'h00FF;
    chk_all("R8 example");
    for (int i = 0; i < 64; i++) begin
      logic [13:0] v;
      v = 14'(16383 - i * 181);
      send({(i % 2 == 0) ? 2'b10 : 2'b01, v});
      if (i % 2 == 0) e_f1[27:14] = v; else e_f0[27:14] = v;
      chk_all("R8");
    end

    // R9 phase sweep, both slots, ignored bit toggled
    for (int v = 0; v < 4096; v += 37) begin
      for (int s = 0; s < 4; s++) begin
        send({2'b11, s[1], s[0], 12'(v + s)});
        if (s[1]) e_p1 = 12'(v + s); else e_p0 = 12'(v + s);
        chk_all("R9");
      end
    end

    // R10 idle cycles with changing word
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_word  = 16'(i * 4369);
      @(negedge clk);
      chk_all("R10");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule